// File: doc/BRIEF.md
# Bus Initialization and Address Assignment Sequencer

This block runs the one-time initialization step of a satellite node on a daisy-chained sensor bus once internal power-on reset has been released. A frame decoder presents decoded command frames as a valid/ready stream. The sequencer accepts the first frame that qualifies as an initialization request. It then assigns the node address and latches the bank select and the nonvolatile-programming enable. Next it asks an external analog stage to test the downstream bus output for a short to the high rail, and records the result as a bus-fault flag.

If the test passes and the request asked for it, the sequencer closes the pass-through switch that powers the next node on the chain. It then holds off for a parameterised blanking interval while the bus voltage settles. After that it offers exactly one 16-bit response word with a 4-bit CRC on a valid/ready stream. The frame decoder can use `busy` to delay its reply slot. Once initialized, the node accepts and ignores every later frame. Back-pressure works as follows. `cmd_ready` is low from the cycle after an accepted request until the response has been taken. The response word and CRC stay stable while `rsp_valid` is high and `rsp_ready` is low.

Top module: `bus_init_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and every other output is 0, including `addr_valid`, `sw_close`, `busy`, `ready`, `rsp_valid` and `test_req`.
- R2: While uninitialized, a frame is a candidate only when its command code is 4'b0000. Any other code is consumed with no address assignment, no bus test and no response.
- R3: With a preprogrammed address (`pre_addr_valid`=1), the request qualifies only if both the frame address and the requested address (data bits 3:0) equal `pre_addr`.
- R4: With no preprogrammed address, the request qualifies only if the frame address is 4'b0000. The requested address then becomes `dev_addr`, and `addr_valid` is 1 from the cycle after acceptance.
- R5: A request whose requested address is 4'b0000 never qualifies.
- R6: Data bits 5:4 select the bank. Only bank codes 2'b00 and 2'b01 are valid, set by a parameter mask. A request with code 2'b10 or 2'b11 never qualifies.
- R7: After acceptance, `test_req` is high from the next cycle until the cycle `test_done` is sampled. `bus_fault` then equals `test_fault`.
- R8: Data bit 6 requests closing the switch. `sw_close` becomes 1 only if that bit is 1 and no bus fault was found, and it then stays closed.
- R9: After the switch closes, `busy` stays high for exactly BLANK_CYC further cycles before `ready` rises. With the switch left open, `ready` rises the cycle after `test_done`. `busy` is high throughout the test and the blanking.
- R10: The response word is {PA, 3'b000, BF, NV, BS, BANK, PA}, MSB first. Data bit 7 is NV, and `nv_enable` and `bank_sel` present the latched NV and BANK.
- R11: `rsp_crc` is the remainder of the response word times x^4 divided by x^4+x+1, which is an all-zero-seeded CRC-4 over the word MSB first.
- R12: Exactly one response is offered. It stays stable while `rsp_ready` is low and is withdrawn in the cycle after it is taken.
- R13: After acceptance, every later frame is consumed without effect. The address, flags and switch do not change, and no further test or response occurs.
- R14: `cmd_ready` is low while `busy` or `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low internal power-on reset |
| cmd_valid | input | 1 | Decoded frame available |
| cmd_ready | output | 1 | Sequencer takes the frame |
| cmd_code | input | 4 | Frame command field |
| cmd_addr | input | 4 | Frame address field |
| cmd_data | input | 8 | Frame data byte: NV[7], BS[6], BANK[5:4], PA[3:0] |
| pre_addr | input | 4 | Preprogrammed address |
| pre_addr_valid | input | 1 | An address is preprogrammed |
| test_req | output | 1 | Request to the analog bus-short test |
| test_done | input | 1 | Bus test finished this cycle |
| test_fault | input | 1 | Bus test result, 1 = short found |
| dev_addr | output | 4 | Assigned node address |
| addr_valid | output | 1 | Address assigned |
| sw_close | output | 1 | Pass-through switch closed |
| bus_fault | output | 1 | Latched bus-fault flag |
| nv_enable | output | 1 | Latched nonvolatile-programming enable |
| bank_sel | output | 2 | Latched bank select |
| busy | output | 1 | Bus test or blanking in progress |
| ready | output | 1 | Initialization complete, blanking over |
| rsp_valid | output | 1 | Response word offered |
| rsp_ready | input | 1 | Response consumer takes the word |
| rsp_word | output | 16 | Initialization response word |
| rsp_crc | output | 4 | CRC of the response word |

## Verification
The hardest cases to reach are the ones that need the whole acceptance path and a particular bus-test outcome together. Switch closure with the full blanking count needs a qualifying address under both address rules, a valid bank, the close bit set and a clean test result. The fault path needs the same qualifying request with a fault reported. The stimulus gets there with a sweep that resets the block for every combination. It crosses the preprogrammed and unprogrammed modes with all sixteen requested addresses, three frame addresses, all four bank codes, the close bit and the test result. The bench answers `test_req` itself after a fixed delay, so each accepted case walks through testing, blanking, a back-pressured response and a trailing ignored frame.

// File: rtl/bus_init_pkg.sv
package bus_init_pkg;

  localparam int ADDR_W = 4;
  localparam int CODE_W = 4;
  localparam int WORD_W = 16;
  localparam int CRC_W  = 4;

  localparam logic [CODE_W-1:0] CODE_INIT = 4'b0000;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_TEST  = 3'd1,
    ST_BLANK = 3'd2,
    ST_RESP  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic              nv;
    logic              bs;
    logic [1:0]        bank;
    logic [ADDR_W-1:0] pa;
  } init_byte_t;

endpackage

// File: rtl/init_req_check.sv
module init_req_check
  import bus_init_pkg::*;
#(
  parameter logic [3:0] BANK_OK_MASK = 4'b0011
) (
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] frame_addr,
  input  init_byte_t        req,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic              pre_valid,
  output logic              qualifies
);

  logic code_ok;
  logic bank_ok;
  logic pa_nonzero;
  logic addr_ok;

  always_comb begin
    code_ok    = (code == CODE_INIT);
    bank_ok    = BANK_OK_MASK[req.bank];
    pa_nonzero = (req.pa != '0);
    if (pre_valid) begin
      addr_ok = (frame_addr == pre_addr) && (req.pa == pre_addr);
    end else begin
      addr_ok = (frame_addr == '0);
    end
    qualifies = code_ok && bank_ok && pa_nonzero && addr_ok;
  end

endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
  parameter int BLANK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int CNT_W = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = run && (cnt_q == LAST);

endmodule

// File: rtl/rsp_crc4.sv
module rsp_crc4 #(
  parameter int         DATA_W = 16,
  parameter logic [3:0] POLY   = 4'b0011,
  parameter logic [3:0] SEED   = 4'b0000
) (
  input  logic [DATA_W-1:0] data,
  output logic [3:0]        crc
);

  always_comb begin
    logic [3:0] c;
    logic       fb;
    c = SEED;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[3] ^ data[i];
      c  = {c[2:0], 1'b0} ^ (fb ? POLY : 4'b0000);
    end
    crc = c;
  end

endmodule

// File: rtl/bus_init_seq.sv
module bus_init_seq
  import bus_init_pkg::*;
#(
  parameter int         BLANK_CYC    = 16,
  parameter logic [3:0] BANK_OK_MASK = 4'b0011,
  parameter logic [3:0] CRC_POLY     = 4'b0011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [3:0]  cmd_code,
  input  logic [3:0]  cmd_addr,
  input  logic [7:0]  cmd_data,
  input  logic [3:0]  pre_addr,
  input  logic        pre_addr_valid,
  output logic        test_req,
  input  logic        test_done,
  input  logic        test_fault,
  output logic [3:0]  dev_addr,
  output logic        addr_valid,
  output logic        sw_close,
  output logic        bus_fault,
  output logic        nv_enable,
  output logic [1:0]  bank_sel,
  output logic        busy,
  output logic        ready,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_word,
  output logic [3:0]  rsp_crc
);

  seq_state_e state_q;
  init_byte_t req;
  init_byte_t lat_q;
  logic       qualifies;
  logic       take;
  logic       blank_over;
  logic       fault_q;
  logic       sw_q;
  logic [ADDR_W-1:0] addr_q;
  logic       addr_set_q;

  assign req = init_byte_t'(cmd_data);

  init_req_check #(
    .BANK_OK_MASK(BANK_OK_MASK)
  ) u_check (
    .code      (cmd_code),
    .frame_addr(cmd_addr),
    .req       (req),
    .pre_addr  (pre_addr),
    .pre_valid (pre_addr_valid),
    .qualifies (qualifies)
  );

  blank_timer #(
    .BLANK_CYC(BLANK_CYC)
  ) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_BLANK),
    .expire(blank_over)
  );

  assign take = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_WAIT;
      lat_q      <= '0;
      fault_q    <= 1'b0;
      sw_q       <= 1'b0;
      addr_q     <= '0;
      addr_set_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (take && qualifies) begin
            lat_q      <= req;
            addr_q     <= req.pa;
            addr_set_q <= 1'b1;
            state_q    <= ST_TEST;
          end
        end
        ST_TEST: begin
          if (test_done) begin
            fault_q <= test_fault;
            if (!test_fault && lat_q.bs) begin
              sw_q    <= 1'b1;
              state_q <= ST_BLANK;
            end else begin
              state_q <= ST_RESP;
            end
          end
        end
        ST_BLANK: begin
          if (blank_over) begin
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          state_q <= ST_DONE;
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  assign cmd_ready  = (state_q == ST_WAIT) || (state_q == ST_DONE);
  assign test_req   = (state_q == ST_TEST);
  assign busy       = (state_q == ST_TEST) || (state_q == ST_BLANK);
  assign ready      = (state_q == ST_RESP) || (state_q == ST_DONE);
  assign rsp_valid  = (state_q == ST_RESP);
  assign dev_addr   = addr_q;
  assign addr_valid = addr_set_q;
  assign sw_close   = sw_q;
  assign bus_fault  = fault_q;
  assign nv_enable  = lat_q.nv;
  assign bank_sel   = lat_q.bank;

  assign rsp_word = {lat_q.pa, 3'b000, fault_q, lat_q.nv, lat_q.bs, lat_q.bank, lat_q.pa};

  rsp_crc4 #(
    .DATA_W(WORD_W),
    .POLY  (CRC_POLY),
    .SEED  (4'b0000)
  ) u_crc (
    .data(rsp_word),
    .crc (rsp_crc)
  );

endmodule

// File: rtl/bus_init_seq_chk.sv
module bus_init_seq_chk #(
  parameter int BLANK_CYC = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        test_req,
  input logic        test_done,
  input logic [3:0]  dev_addr,
  input logic        addr_valid,
  input logic        sw_close,
  input logic        bus_fault,
  input logic        busy,
  input logic        ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_word,
  input logic [3:0]  rsp_crc
);

  int blank_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_seen <= 0;
    end else if (sw_close && busy) begin
      blank_seen <= blank_seen + 1;
    end
  end

  // R14
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || rsp_valid) |-> !cmd_ready);

  // R8
  sw_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_close |-> !bus_fault);

  // R8
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_close |=> sw_close);

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_word) && $stable(rsp_crc)));

  // R12
  rsp_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> !rsp_valid);

  // R10
  rsp_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_word[15:12] == rsp_word[3:0] && rsp_word[11:9] == 3'b000
                   && rsp_word[3:0] == dev_addr));

  // R13
  addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> (addr_valid && $stable(dev_addr)));

  // R9
  blank_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && sw_close) |-> (blank_seen == BLANK_CYC));

  // R7
  test_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !test_done) |=> (test_req && busy));

  // R9
  ready_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (addr_valid && !busy));

endmodule

bind bus_init_seq bus_init_seq_chk #(.BLANK_CYC(BLANK_CYC)) u_bus_init_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .test_req  (test_req),
  .test_done (test_done),
  .dev_addr  (dev_addr),
  .addr_valid(addr_valid),
  .sw_close  (sw_close),
  .bus_fault (bus_fault),
  .busy      (busy),
  .ready     (ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_word  (rsp_word),
  .rsp_crc   (rsp_crc)
);

// File: tb/test_bus_init_seq.sv
`timescale 1ns/1ps
module test_bus_init_seq;

  localparam int BLANK = 5;
  localparam logic [3:0] PRE = 4'h9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_code = '0;
  logic [3:0]  cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic [3:0]  pre_addr = '0;
  logic        pre_addr_valid = 1'b0;
  logic        test_req;
  logic        test_done = 1'b0;
  logic        test_fault = 1'b0;
  logic [3:0]  dev_addr;
  logic        addr_valid;
  logic        sw_close;
  logic        bus_fault;
  logic        nv_enable;
  logic [1:0]  bank_sel;
  logic        busy;
  logic        ready;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_word;
  logic [3:0]  rsp_crc;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  bus_init_seq #(.BLANK_CYC(BLANK)) i_bus_init_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .pre_addr(pre_addr), .pre_addr_valid(pre_addr_valid),
    .test_req(test_req), .test_done(test_done), .test_fault(test_fault),
    .dev_addr(dev_addr), .addr_valid(addr_valid), .sw_close(sw_close),
    .bus_fault(bus_fault), .nv_enable(nv_enable), .bank_sel(bank_sel),
    .busy(busy), .ready(ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_word(rsp_word), .rsp_crc(rsp_crc)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_crc(input logic [15:0] w);
    logic [19:0] v;
    v = {w, 4'b0000};
    for (int i = 19; i >= 4; i--) begin
      if (v[i]) v = v ^ (20'h13 << (i - 4));
    end
    return v[3:0];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    test_done = 1'b0;
    rsp_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [3:0] code, input logic [3:0] fa, input logic [7:0] d);
    cmd_code = code;
    cmd_addr = fa;
    cmd_data = d;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_case(input bit pv, input logic [3:0] pa, input logic [3:0] fa,
                          input logic [1:0] bk, input bit bs, input bit nv,
                          input bit flt, input logic [3:0] code);
    bit acc;
    bit cls;
    int blank;
    logic [15:0] w;
    do_reset();
    // R1 reset state
    chk(cmd_ready && !addr_valid && !sw_close && !busy && !ready && !rsp_valid && !test_req
        && !bus_fault && !nv_enable && bank_sel == 0 && dev_addr == 0,
        "R1", {cmd_ready, addr_valid, sw_close, busy, ready, rsp_valid, test_req}, 7'b1000000);
    pre_addr = PRE;
    pre_addr_valid = pv;
    acc = (code == 0) && (pa != 0) && (bk < 2) && (pv ? (fa == PRE && pa == PRE) : (fa == 0));
    send(code, fa, {nv, bs, bk, pa});
    if (!acc) begin
      repeat (3) @(negedge clk);
      // R2 R3 R4 R5 R6 rejected request
      chk(!test_req && !addr_valid && !rsp_valid && !busy && cmd_ready,
          (code != 0) ? "R2" : (pa == 0) ? "R5" : (bk >= 2) ? "R6" : pv ? "R3" : "R4",
          {test_req, addr_valid, rsp_valid, busy}, 0);
      return;
    end
    // R3 R4 address assigned, R7 R14 test started
    chk(addr_valid && dev_addr == pa, pv ? "R3" : "R4", dev_addr, pa);
    chk(test_req && busy && !cmd_ready, "R7", {test_req, busy, cmd_ready}, 3'b110);
    repeat (2) @(negedge clk);
    chk(test_req && busy && !cmd_ready, "R14", {test_req, busy, cmd_ready}, 3'b110);
    test_done = 1'b1;
    test_fault = flt;
    @(negedge clk);
    test_done = 1'b0;
    cls = !flt && bs;
    chk(bus_fault == flt && !test_req, "R7", bus_fault, flt);
    chk(sw_close == cls, "R8", sw_close, cls);
    blank = 0;
    for (int k = 0; k < 50 && !ready; k++) begin
      if (busy) blank++;
      @(negedge clk);
    end
    chk(ready && blank == (cls ? BLANK : 0), "R9", blank, cls ? BLANK : 0);
    w = {pa, 3'b000, flt, nv, bs, bk, pa};
    chk(rsp_valid && rsp_word == w, "R10", rsp_word, w);
    chk(nv_enable == nv && bank_sel == bk, "R10", {nv_enable, bank_sel}, {nv, bk});
    chk(rsp_crc == ref_crc(w), "R11", rsp_crc, ref_crc(w));
    repeat (3) @(negedge clk);
    chk(rsp_valid && rsp_word == w && rsp_crc == ref_crc(w), "R12", rsp_word, w);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && cmd_ready, "R12", {rsp_valid, cmd_ready}, 2'b01);
    send(4'h0, 4'h0, {~nv, ~bs, 2'b00, pa ^ 4'h6});
    repeat (3) @(negedge clk);
    // R13 later frame ignored
    chk(!rsp_valid && !test_req && dev_addr == pa && sw_close == cls
        && nv_enable == nv && bank_sel == bk && bus_fault == flt,
        "R13", {rsp_valid, test_req, dev_addr}, {2'b00, pa});
  endtask

  initial begin
    for (int pv = 0; pv < 2; pv++) begin
      for (int pa = 0; pa < 16; pa++) begin
        for (int f = 0; f < 3; f++) begin
          for (int bk = 0; bk < 4; bk++) begin
            for (int bs = 0; bs < 2; bs++) begin
              for (int flt = 0; flt < 2; flt++) begin
                logic [3:0] fa;
                fa = (f == 0) ? 4'h0 : (f == 1) ? PRE : 4'(pa);
                run_case(pv[0], 4'(pa), fa, 2'(bk), bs[0], pa[0], flt[0], 4'h0);
              end
            end
          end
        end
      end
    end
    // R2 every non-initialization command code is ignored
    for (int c = 1; c < 16; c++) begin
      run_case(1'b0, 4'h5, 4'h0, 2'b01, 1'b1, 1'b1, 1'b0, 4'(c));
    end
    finish_run();
  end

endmodule